// File: doc/BRIEF.md
# Multicart Outer-Bank Supervisor Registers

This block holds the supervisor configuration of a multi-game cartridge. It sits beside the cartridge's CPU bus. Writes into the 0x5000–0x5FFF window load four eight-bit configuration registers. One of them is a write-once register that closes itself when its top bit is set. From those registers the block assembles an outer offset that selects which game the cartridge presents.

The block also holds the inner bank latch. Any CPU write to the upper half of the address space (0x8000–0xFFFF) loads it. The block then merges the latch with the outer offset to give the bank numbers for two 16 KiB program windows. The lower window is switchable. The upper window is fixed to the last bank of the selected game.

The block also exports a nametable mirroring select, a four-bit mode field and the raw third register, for the neighbouring personality logic to decode. A read of one status address reports the output bit of an external serial configuration store.

Top module: `mc_outer_bank`

## Requirements
- R1: After synchronous reset the registers hold cfg=0x0F, outer=0xFF, ext=0x00 and lock=0x00, and the inner latch holds 0x00. At the ports this gives outer_ofs=0x1FF0, bank_lo=0x0FF8, bank_hi=0x0FFF, mirror_horiz=1, mode=0 and ext_cfg=0x00.
- R2: A write to 0x5700 loads the cfg register. From the next cycle, mode equals cfg[7:4], mirror_horiz equals cfg[2] (1 = horizontal, 0 = vertical) and outer_ofs bit 4 equals cfg[0].
- R3: A write to 0x5701 loads the outer register, which appears as outer_ofs[12:5].
- R4: A write to 0x5702 loads the ext register, which appears on ext_cfg.
- R5: A write to 0x5601 loads the lock register while its bit 7 is clear. Lock bit 4 appears as outer_ofs bit 13. outer_ofs bits 3..0 are always zero.
- R6: Once lock bit 7 is set, writes to 0x5601 are ignored until the next reset.
- R7: The inner mask is 0x07 when cfg[1] is set and 0x0F when it is clear.
- R8: bank_lo = (latch AND mask) OR ((outer_ofs >> 1) AND NOT mask).
- R9: bank_hi = (outer_ofs >> 1) OR mask.
- R10: Every write with an address in 0x8000–0xFFFF loads the inner latch from the data bus. Writes below 0x8000 leave it unchanged.
- R11: cpu_rdata is 0x80 when cpu_addr is 0x5301 and ser_bit is high, and 0x00 when cpu_addr is 0x5301 and ser_bit is low. At every other address it is 0xFF.
- R12: Writes to addresses in 0x5000–0x5FFF other than 0x5601, 0x5700, 0x5701 and 0x5702 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| ser_bit | input | 1 | Output bit of the serial configuration store |
| cpu_rdata | output | 8 | Read data for the supervisor window |
| outer_ofs | output | 14 | Assembled outer offset |
| bank_lo | output | 13 | 16 KiB bank for the switchable lower window |
| bank_hi | output | 13 | 16 KiB bank for the fixed upper window |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| mode | output | 4 | Personality mode field |
| ext_cfg | output | 8 | Third supervisor register, raw |

## Verification
The hardest condition to reach is a lock register that is closed but still drives the offset. That takes a write that sets bit 7 and so closes the register, then a further write that tries to change bit 4, and finally a reset that must reopen the register. The stimulus table first opens bit 4 and confirms it reaches outer_ofs. It then closes the register with a value whose bit 4 is clear, and shows that a later write setting bit 4 leaves outer_ofs bit 13 low. A directed reset then shows the same write accepted. The mask boundary is reached with a latch value whose bit 3 is set and an outer offset whose bit 3 is clear, so that the two mask widths give different lower-window banks.

// File: rtl/mc_outer_bank_pkg.sv
// Package: shared widths, decoded addresses and the supervisor register type.
// Assumes a 16-bit CPU address and an 8-bit data bus.
package mc_outer_bank_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned OFS_W  = 14;
    localparam int unsigned BANK_W = OFS_W - 1;

    localparam logic [ADDR_W-1:0] A_CFG   = 16'h5700;
    localparam logic [ADDR_W-1:0] A_OUTER = 16'h5701;
    localparam logic [ADDR_W-1:0] A_EXT   = 16'h5702;
    localparam logic [ADDR_W-1:0] A_LOCK  = 16'h5601;
    localparam logic [ADDR_W-1:0] A_SER   = 16'h5301;

    localparam logic [DATA_W-1:0] CFG_RST   = 8'h0F;
    localparam logic [DATA_W-1:0] OUTER_RST = 8'hFF;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] outer;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] lockreg;
    } sup_regs_t;
endpackage

// File: rtl/mc_sup_regfile.sv
// Supervisor register file: decodes writes in the supervisor window into four
// registers, keeps the lock register closed once its bit 7 is set, and drives
// the read data for the status address. Assumes one-cycle write strobes.
module mc_sup_regfile
    import mc_outer_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ser_bit,
    output sup_regs_t         regs,
    output logic [DATA_W-1:0] rdata
);
    // Register update: reset values, decoded loads, write-once lock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs.cfg     <= CFG_RST;
            regs.outer   <= OUTER_RST;
            regs.ext     <= '0;
            regs.lockreg <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG:   regs.cfg   <= wdata;
                A_OUTER: regs.outer <= wdata;
                A_EXT:   regs.ext   <= wdata;
                A_LOCK:  if (!regs.lockreg[DATA_W-1]) regs.lockreg <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux: status bit on the serial address, all ones elsewhere.
    always_comb begin
        if (addr == A_SER) rdata = {ser_bit, {(DATA_W-1){1'b0}}};
        else               rdata = '1;
    end

    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs.lockreg[DATA_W-1] |=> $stable(regs.lockreg));

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_CFG) |=> $stable(regs.cfg));

    p_outer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OUTER) |=> regs.outer == $past(wdata));

    p_ser_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_SER) |-> $countones(rdata[DATA_W-2:0]) == 0);
endmodule

// File: rtl/mc_inner_latch.sv
// Inner bank latch: captures the data bus on each write to the upper half of
// the address space. The caller supplies the decoded load strobe.
module mc_inner_latch
    import mc_outer_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Latch register: clear on reset, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    p_latch_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(d));

    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/mc_bank_merge.sv
// Bank merge: assembles the outer offset from scattered register bits and
// combines it with the inner latch for the two 16 KiB windows. Purely
// combinational; clk and rst_n serve the assertions only.
module mc_bank_merge
    import mc_outer_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sup_regs_t         regs,
    input  logic [DATA_W-1:0] latch,
    output logic [OFS_W-1:0]  outer_ofs,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi
);
    logic [BANK_W-1:0] mask;
    logic [BANK_W-1:0] ofs_bank;
    logic [BANK_W-1:0] latch_ext;
    logic              unused_bits;

    // Offset assembly: lock bit 4, outer byte, cfg bit 0, four zero bits.
    always_comb outer_ofs = {regs.lockreg[4], regs.outer, regs.cfg[0], 4'b0000};

    // Mask selection and window bank computation.
    always_comb begin
        mask      = regs.cfg[1] ? BANK_W'(7) : BANK_W'(15);
        ofs_bank  = outer_ofs[OFS_W-1:1];
        latch_ext = BANK_W'(latch);
        bank_lo   = (latch_ext & mask) | (ofs_bank & ~mask);
        bank_hi   = ofs_bank | mask;
    end

    assign unused_bits = ^{regs.cfg[7:2], regs.ext, regs.lockreg[7:5],
                           regs.lockreg[3:0], outer_ofs[0]};

    p_bank_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_lo[BANK_W-1:4] == bank_hi[BANK_W-1:4]);

    p_hi_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_hi[2:0] == 3'b111);

    p_ofs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        outer_ofs[3:0] == 4'b0000);
endmodule

// File: rtl/mc_outer_bank.sv
// Top: multicart supervisor registers with inner/outer bank merge for the
// 16 KiB switchable mode. Assumes single-cycle CPU write strobes and a
// synchronous active-low reset.
module mc_outer_bank
    import mc_outer_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic              ser_bit,
    output logic [7:0]        cpu_rdata,
    output logic [13:0]       outer_ofs,
    output logic [12:0]       bank_lo,
    output logic [12:0]       bank_hi,
    output logic              mirror_horiz,
    output logic [3:0]        mode,
    output logic [7:0]        ext_cfg
);
    sup_regs_t         regs;
    logic [DATA_W-1:0] latch_q;
    logic              latch_ld;

    // Latch strobe: any write to the upper half of the address space.
    always_comb latch_ld = cpu_we && cpu_addr[ADDR_W-1];

    mc_sup_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_we), .addr(cpu_addr),
        .wdata(cpu_wdata), .ser_bit(ser_bit), .regs(regs), .rdata(cpu_rdata)
    );

    mc_inner_latch u_latch (
        .clk(clk), .rst_n(rst_n), .ld(latch_ld), .d(cpu_wdata), .q(latch_q)
    );

    mc_bank_merge u_merge (
        .clk(clk), .rst_n(rst_n), .regs(regs), .latch(latch_q),
        .outer_ofs(outer_ofs), .bank_lo(bank_lo), .bank_hi(bank_hi)
    );

    // Field outputs taken straight from the cfg and ext registers.
    always_comb begin
        mirror_horiz = regs.cfg[2];
        mode         = regs.cfg[7:4];
        ext_cfg      = regs.ext;
    end

    p_mode_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_CFG) |=> mode == $past(cpu_wdata[7:4]));
endmodule

// File: tb/mc_outer_bank_test.sv
`timescale 1ns/1ps
module mc_outer_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        ser_bit = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [13:0] outer_ofs;
    logic [12:0] bank_lo, bank_hi;
    logic        mirror_horiz;
    logic [3:0]  mode;
    logic [7:0]  ext_cfg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mc_outer_bank uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ser_bit(ser_bit), .cpu_rdata(cpu_rdata),
        .outer_ofs(outer_ofs), .bank_lo(bank_lo), .bank_hi(bank_hi),
        .mirror_horiz(mirror_horiz), .mode(mode), .ext_cfg(ext_cfg)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic [13:0] ofs;
        logic [12:0] lo;
        logic [12:0] hi;
        logic        mir;
        logic [3:0]  md;
        logic [7:0]  ext;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h8000, 8'h2D, 14'h1FF0, 13'h0FFD, 13'h0FFF, 1'b1, 4'h0, 8'h00}, // R10 R8
        '{16'h5700, 8'h30, 14'h1FE0, 13'h0FFD, 13'h0FFF, 1'b0, 4'h3, 8'h00}, // R2 R7
        '{16'h5701, 8'h5A, 14'h0B40, 13'h05AD, 13'h05AF, 1'b0, 4'h3, 8'h00}, // R3
        '{16'h5700, 8'h97, 14'h0B50, 13'h05AD, 13'h05AF, 1'b1, 4'h9, 8'h00}, // R2 R7
        '{16'hFFFF, 8'h03, 14'h0B50, 13'h05AB, 13'h05AF, 1'b1, 4'h9, 8'h00}, // R10
        '{16'h5601, 8'h10, 14'h2B50, 13'h15AB, 13'h15AF, 1'b1, 4'h9, 8'h00}, // R5
        '{16'h6000, 8'hFF, 14'h2B50, 13'h15AB, 13'h15AF, 1'b1, 4'h9, 8'h00}, // R10
        '{16'h5601, 8'h80, 14'h0B50, 13'h05AB, 13'h05AF, 1'b1, 4'h9, 8'h00}, // R5 closes
        '{16'h5601, 8'h10, 14'h0B50, 13'h05AB, 13'h05AF, 1'b1, 4'h9, 8'h00}, // R6
        '{16'h5700, 8'h0C, 14'h0B40, 13'h05A3, 13'h05AF, 1'b1, 4'h0, 8'h00}, // R7 R9
        '{16'h5123, 8'h00, 14'h0B40, 13'h05A3, 13'h05AF, 1'b1, 4'h0, 8'h00}, // R12
        '{16'h5702, 8'hA5, 14'h0B40, 13'h05A3, 13'h05AF, 1'b1, 4'h0, 8'hA5}  // R4
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = 16'h0000;
    endtask

    function automatic logic [63:0] pack_out(input logic [13:0] o, input logic [12:0] l,
                                             input logic [12:0] h, input logic m,
                                             input logic [3:0] md, input logic [7:0] e);
        return {11'd0, o, l, h, m, md, e};
    endfunction

    initial begin
        do_reset();
        // R1: reset state at the ports
        check("R1 reset outputs",
              pack_out(outer_ofs, bank_lo, bank_hi, mirror_horiz, mode, ext_cfg),
              pack_out(14'h1FF0, 13'h0FF8, 13'h0FFF, 1'b1, 4'h0, 8'h00));

        // Stimulus table walk (R2..R10, R12)
        for (int i = 0; i < NV; i++) begin
            cpu_write(VECS[i].addr, VECS[i].data);
            check($sformatf("R2-table vector %0d (R3 R4 R5 R6 R7 R8 R9 R10 R12)", i),
                  pack_out(outer_ofs, bank_lo, bank_hi, mirror_horiz, mode, ext_cfg),
                  pack_out(VECS[i].ofs, VECS[i].lo, VECS[i].hi, VECS[i].mir,
                           VECS[i].md, VECS[i].ext));
        end

        // R11: read mux
        @(negedge clk);
        cpu_addr = 16'h5301; ser_bit = 1'b1;
        #1 check("R11 status high", cpu_rdata, 8'h80);
        ser_bit = 1'b0;
        #1 check("R11 status low", cpu_rdata, 8'h00);
        cpu_addr = 16'h5601; ser_bit = 1'b1;
        #1 check("R11 other address", cpu_rdata, 8'hFF);
        cpu_addr = 16'h5700;
        #1 check("R11 cfg address", cpu_rdata, 8'hFF);

        // R6: reset reopens the lock register
        do_reset();
        cpu_write(16'h5601, 8'h10);
        check("R6 reopened after reset / R5 bit13", outer_ofs, 14'h3FF0);

        // R7: mask boundary, latch bit 3 set, offset bit 3 clear
        cpu_write(16'h8000, 8'h1A);
        cpu_write(16'h5700, 8'h0E);
        check("R7 mask 7 lower bank", bank_lo, 13'h1FF2);
        check("R9 mask 7 upper bank", bank_hi, 13'h1FF7);
        cpu_write(16'h5700, 8'h0C);
        check("R7 mask 15 lower bank", bank_lo, 13'h1FFA);
        check("R9 mask 15 upper bank", bank_hi, 13'h1FFF);

        // R12: unused window address, then R10 low write leaves latch
        cpu_write(16'h5FFF, 8'h00);
        check("R12 unused window write", {outer_ofs, mode, ext_cfg}, {14'h3FE0, 4'h0, 8'h00});
        cpu_write(16'h7FFF, 8'h05);
        check("R10 write below 0x8000", bank_lo, 13'h1FFA);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule